// File: doc/BRIEF.md
# Toroidal Eight-Way Bit-Serial Exchange Fabric

This block moves data between the processing elements of a small SIMD array laid out as a grid of `ROWS` by `COLS`. Each element holds a source word and a destination word, both `WIDTH` bits. In an exchange, every element sends its source word to one neighbour, one bit per clock with the least significant bit first. At the same time it receives the source word of the element on its opposite side. A central controller picks one of eight compass directions for the whole array. Links at the grid edges wrap around in both dimensions, so the array behaves as a torus.

Two scalar paths run beside the exchange. A broadcast writes one controller word into the destination register of every enabled element. An OR reduction combines the source words of all enabled elements into one word that the controller reads. A per-element enable bit masks destination writes and reduction membership. The source chain keeps moving through disabled elements. The controller loads source words one element at a time and reads back any destination word through an index.

Top module: `nbr_mesh`

## Requirements
- R1: After reset, every source and destination word is zero, `reduceData` is zero, and `busy` and `done` are low.
- R2: While `busy` is low, `loadEn` writes `loadData` into the source word of element `loadIdx`. The index is row*COLS+col, with row 0 at the north edge and column 0 at the west edge. `readData` shows the destination word of element `readIdx` without a clock delay.
- R3: A start with opcode 0 runs an exchange in direction `dirSel`. The codes are 0=N, 1=NE, 2=E, 3=SE, 4=S, 5=SW, 6=W, 7=NW, where north lowers the row and east raises the column. Afterwards, every enabled element (r,c) holds in its destination the former source word of element (r-dr, c-dc), where (dr,dc) is the step of the chosen direction. Every element's source word takes that same value.
- R4: Neighbour indices wrap modulo ROWS and modulo COLS. A diagonal exchange at a corner wraps on both axes at once.
- R5: A disabled element keeps its destination word through an exchange, but it still passes bits along, so its source word is updated as in R3.
- R6: A start with opcode 1 writes `bcastData`, sampled at start, into the destination word of every enabled element. It leaves disabled elements and all source words unchanged.
- R7: A start with opcode 2 sets `reduceData` to the bitwise OR of the source words of the enabled elements, or to zero when none is enabled. `reduceData` changes only when a reduction completes.
- R8: `busy` is high for exactly WIDTH cycles for an exchange and for one cycle for a broadcast or a reduction. `done` is a single-cycle pulse in the cycle right after the last busy cycle.
- R9: A start while `busy` is high is ignored. A start with opcode 3 is ignored and never raises `busy`.
- R10: `loadEn` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation request pulse |
| opcode | input | 2 | 0 exchange, 1 broadcast, 2 OR reduction, 3 no operation |
| dirSel | input | 3 | Exchange direction code |
| bcastData | input | WIDTH | Broadcast word |
| peEnable | input | ROWS*COLS | Per-element enable mask |
| loadEn | input | 1 | Source word write strobe |
| loadIdx | input | $clog2(ROWS*COLS) | Element index for the write |
| loadData | input | WIDTH | Source word to write |
| readIdx | input | $clog2(ROWS*COLS) | Element index for readback |
| readData | output | WIDTH | Destination word of element readIdx |
| reduceData | output | WIDTH | Result of the last OR reduction |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are a second start or a source load arriving in the middle of a 32-cycle exchange. Either one would corrupt the bit chain. The bench injects both at the fifth busy cycle. It then runs the reverse exchange and checks that every element's destination returns to its original source word. It also sweeps all eight directions against an arithmetic torus model, with masks that cover the wrap corners, and runs reductions with full, single, partial and empty masks.

// File: rtl/nbr_mesh_pkg.sv
package nbr_mesh_pkg;
  typedef enum logic [2:0] {
    DIR_N, DIR_NE, DIR_E, DIR_SE, DIR_S, DIR_SW, DIR_W, DIR_NW
  } dir_e;

  typedef enum logic [1:0] {
    OP_SHIFT = 2'd0, OP_BCAST = 2'd1, OP_REDUCE = 2'd2, OP_NONE = 2'd3
  } op_e;

  typedef struct packed {
    logic shiftEn;
    logic bcastEn;
    logic reduceEn;
    dir_e dir;
  } strobe_t;
endpackage

// File: rtl/nbr_mesh_ctrl.sv
module nbr_mesh_ctrl
  import nbr_mesh_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opcode,
  input  logic [2:0]       dirSel,
  input  logic [WIDTH-1:0] bcastIn,
  output strobe_t          stb,
  output logic [WIDTH-1:0] bcastWord,
  output logic             busy,
  output logic             done
);
  localparam int CNTW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic            running;
  logic [CNTW-1:0] beatCnt;
  op_e             opQ;
  dir_e            dirQ;
  logic            accept;
  logic            lastBeat;

  assign accept   = start && !running && (op_e'(opcode) != OP_NONE);
  assign lastBeat = (opQ != OP_SHIFT) || (beatCnt == CNTW'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running   <= 1'b0;
      beatCnt   <= '0;
      opQ       <= OP_NONE;
      dirQ      <= DIR_N;
      bcastWord <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        running   <= 1'b1;
        beatCnt   <= '0;
        opQ       <= op_e'(opcode);
        dirQ      <= dir_e'(dirSel);
        bcastWord <= bcastIn;
      end else if (running) begin
        beatCnt <= beatCnt + 1'b1;
        if (lastBeat) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stb.shiftEn  = running && (opQ == OP_SHIFT);
    stb.bcastEn  = running && (opQ == OP_BCAST);
    stb.reduceEn = running && (opQ == OP_REDUCE);
    stb.dir      = dirQ;
  end

  assign busy = running;
endmodule

// File: rtl/nbr_mesh_dp.sv
module nbr_mesh_dp
  import nbr_mesh_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int WIDTH = 32,
  localparam int NPE  = ROWS * COLS,
  localparam int IDXW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [WIDTH-1:0] bcastWord,
  input  logic [NPE-1:0]   peEnable,
  input  logic             loadEn,
  input  logic [IDXW-1:0]  loadIdx,
  input  logic [WIDTH-1:0] loadData,
  input  logic [IDXW-1:0]  readIdx,
  output logic [WIDTH-1:0] readData,
  output logic [WIDTH-1:0] reduceData
);
  logic [NPE*WIDTH-1:0] srcFlat;
  logic [NPE*WIDTH-1:0] dstFlat;
  logic [WIDTH-1:0]     orAll;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      localparam int RN  = (r + 1) % ROWS;
      localparam int RS  = (r + ROWS - 1) % ROWS;
      localparam int CE  = (c + 1) % COLS;
      localparam int CW  = (c + COLS - 1) % COLS;

      logic [WIDTH-1:0] srcQ;
      logic [WIDTH-1:0] dstQ;
      logic             rxBit;

      // Each element receives from the neighbour on the side opposite the flow.
      always_comb begin
        case (stb.dir)
          DIR_N:   rxBit = srcFlat[(RN * COLS + c)  * WIDTH];
          DIR_NE:  rxBit = srcFlat[(RN * COLS + CW) * WIDTH];
          DIR_E:   rxBit = srcFlat[(r  * COLS + CW) * WIDTH];
          DIR_SE:  rxBit = srcFlat[(RS * COLS + CW) * WIDTH];
          DIR_S:   rxBit = srcFlat[(RS * COLS + c)  * WIDTH];
          DIR_SW:  rxBit = srcFlat[(RS * COLS + CE) * WIDTH];
          DIR_W:   rxBit = srcFlat[(r  * COLS + CE) * WIDTH];
          default: rxBit = srcFlat[(RN * COLS + CE) * WIDTH];
        endcase
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          srcQ <= '0;
          dstQ <= '0;
        end else if (stb.shiftEn) begin
          srcQ <= {rxBit, srcQ[WIDTH-1:1]};
          if (peEnable[IDX]) dstQ <= {rxBit, dstQ[WIDTH-1:1]};
        end else begin
          if (loadEn && (loadIdx == IDXW'(IDX))) srcQ <= loadData;
          if (stb.bcastEn && peEnable[IDX])      dstQ <= bcastWord;
        end
      end

      assign srcFlat[IDX*WIDTH +: WIDTH] = srcQ;
      assign dstFlat[IDX*WIDTH +: WIDTH] = dstQ;
    end
  end

  always_comb begin
    orAll = '0;
    for (int i = 0; i < NPE; i++) begin
      if (peEnable[i]) orAll = orAll | srcFlat[i*WIDTH +: WIDTH];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             reduceData <= '0;
    else if (stb.reduceEn) reduceData <= orAll;
  end

  assign readData = dstFlat[int'(readIdx)*WIDTH +: WIDTH];
endmodule

// File: rtl/nbr_mesh.sv
module nbr_mesh
  import nbr_mesh_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 8,
  parameter int WIDTH = 32,
  localparam int NPE  = ROWS * COLS,
  localparam int IDXW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opcode,
  input  logic [2:0]       dirSel,
  input  logic [WIDTH-1:0] bcastData,
  input  logic [NPE-1:0]   peEnable,
  input  logic             loadEn,
  input  logic [IDXW-1:0]  loadIdx,
  input  logic [WIDTH-1:0] loadData,
  input  logic [IDXW-1:0]  readIdx,
  output logic [WIDTH-1:0] readData,
  output logic [WIDTH-1:0] reduceData,
  output logic             busy,
  output logic             done
);
  strobe_t          stb;
  logic [WIDTH-1:0] bcastWord;

  nbr_mesh_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .dirSel(dirSel),
    .bcastIn(bcastData), .stb(stb), .bcastWord(bcastWord), .busy(busy), .done(done)
  );

  nbr_mesh_dp #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bcastWord(bcastWord), .peEnable(peEnable),
    .loadEn(loadEn && !busy), .loadIdx(loadIdx), .loadData(loadData),
    .readIdx(readIdx), .readData(readData), .reduceData(reduceData)
  );
endmodule

// File: rtl/nbr_mesh_chk.sv
module nbr_mesh_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [1:0]       opcode,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] reduceData
);
  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_BUSY_MAX_LEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < WIDTH); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy)); // R8
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start) && $past(opcode) != 2'd3); // R9
  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opcode == 2'd3) |=> !busy); // R9
  AST_REDUCE_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(reduceData) |-> done); // R7
endmodule

bind nbr_mesh nbr_mesh_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
  .busy(busy), .done(done), .reduceData(reduceData)
);

// File: tb/nbr_mesh_tb.sv
module nbr_mesh_tb;
  localparam int ROWS  = 4;
  localparam int COLS  = 8;
  localparam int WIDTH = 32;
  localparam int NPE   = ROWS * COLS;
  localparam int IDXW  = $clog2(NPE);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       opcode = '0;
  logic [2:0]       dirSel = '0;
  logic [WIDTH-1:0] bcastData = '0;
  logic [NPE-1:0]   peEnable = '1;
  logic             loadEn = 1'b0;
  logic [IDXW-1:0]  loadIdx = '0;
  logic [WIDTH-1:0] loadData = '0;
  logic [IDXW-1:0]  readIdx = '0;
  logic [WIDTH-1:0] readData;
  logic [WIDTH-1:0] reduceData;
  logic             busy;
  logic             done;

  int checks = 0;
  int errors = 0;

  logic [WIDTH-1:0] srcM [NPE];
  logic [WIDTH-1:0] dstM [NPE];
  logic [WIDTH-1:0] redM = '0;

  always #4 clk = ~clk;

  nbr_mesh #(.ROWS(ROWS), .COLS(COLS), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .dirSel(dirSel),
    .bcastData(bcastData), .peEnable(peEnable), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .readIdx(readIdx), .readData(readData),
    .reduceData(reduceData), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] pattern(input int i, input int s);
    return {8'(i), 8'(s + 8'h50), 8'(i * 7 + s * 13), 8'(~i)};
  endfunction

  // Step (dr, dc) of each direction code; north lowers the row, east raises the column.
  function automatic int stepR(input int d);
    case (d)
      0, 1, 7: return -1;
      3, 4, 5: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int stepC(input int d);
    case (d)
      1, 2, 3: return 1;
      5, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

  task automatic loadAll(input int s);
    for (int i = 0; i < NPE; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadIdx = IDXW'(i); loadData = pattern(i, s);
      srcM[i] = pattern(i, s);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < NPE; i++) begin
      readIdx = IDXW'(i);
      #1;
      check(req, readData, dstM[i]);
    end
  endtask

  // intr: 0 none, 1 stray start at busy cycle 5, 2 stray load at busy cycle 5
  task automatic doOp(input int op, input int d, input logic [WIDTH-1:0] w,
                      input int intr, input string req);
    int n;
    int expLen;
    logic [WIDTH-1:0] nSrc [NPE];
    @(negedge clk);
    start = 1'b1; opcode = 2'(op); dirSel = 3'(d); bcastData = w;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (busy) begin
      n++;
      start  = (intr == 1 && n == 5);
      opcode = (intr == 1 && n == 5) ? 2'd1 : 2'(op);
      bcastData = ~w;
      loadEn = (intr == 2 && n == 5);
      loadIdx = 3; loadData = 32'hDEAD_BEEF;
      @(negedge clk);
    end
    start = 1'b0; loadEn = 1'b0;
    expLen = (op == 0) ? WIDTH : 1;
    check({req, " R8 busy length"}, n, expLen);
    check({req, " R8 done pulse"}, WIDTH'(done), 1);
    if (op == 0) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int c = 0; c < COLS; c++) begin
          int sr = (r - stepR(d) + ROWS) % ROWS;
          int sc = (c - stepC(d) + COLS) % COLS;
          nSrc[r*COLS+c] = srcM[sr*COLS+sc];
        end
      end
      for (int i = 0; i < NPE; i++) begin
        if (peEnable[i]) dstM[i] = nSrc[i];
        srcM[i] = nSrc[i];
      end
    end else if (op == 1) begin
      for (int i = 0; i < NPE; i++) if (peEnable[i]) dstM[i] = w;
    end else if (op == 2) begin
      redM = '0;
      for (int i = 0; i < NPE; i++) if (peEnable[i]) redM |= srcM[i];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] held;
    for (int i = 0; i < NPE; i++) begin srcM[i] = '0; dstM[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", WIDTH'(busy), 0);
    check("R1 done", WIDTH'(done), 0);
    check("R1 reduceData", reduceData, 0);
    checkAll("R1 dst zero");

    // R2 load then R3 all eight directions (R4 wrap covered at every edge)
    for (int d = 0; d < 8; d++) begin
      loadAll(d);
      peEnable = '1;
      doOp(0, d, '0, 0, "R3");
      checkAll("R3 R4 exchange");
    end

    // R5 partial mask, includes corner elements on both settings
    loadAll(11);
    peEnable = 32'hA5C3_3C5A;
    doOp(0, 3, '0, 0, "R5");
    checkAll("R5 masked exchange SE");
    peEnable = 32'h0F0F_8001;
    doOp(0, 5, '0, 0, "R5");
    checkAll("R5 masked exchange SW");

    // R10 stray load mid-exchange, then reverse exchange restores the words
    peEnable = '1;
    loadAll(21);
    doOp(0, 1, '0, 2, "R10");
    checkAll("R10 exchange with stray load");
    doOp(0, 5, '0, 0, "R10");
    for (int i = 0; i < NPE; i++) begin
      readIdx = IDXW'(i); #1;
      check("R10 round trip", readData, pattern(i, 21));
    end

    // R9 stray start mid-exchange is ignored
    doOp(0, 6, '0, 1, "R9");
    checkAll("R9 exchange with stray start");

    // R6 broadcast with masks
    peEnable = 32'h1234_8765;
    doOp(1, 0, 32'hCAFE_F00D, 0, "R6");
    checkAll("R6 masked broadcast");
    peEnable = '1;
    doOp(1, 0, 32'h0BAD_1DEA, 0, "R6");
    checkAll("R6 full broadcast");

    // R7 reductions: full, single, partial, none
    loadAll(33);
    peEnable = '1;
    doOp(2, 0, '0, 0, "R7");
    check("R7 OR all", reduceData, redM);
    peEnable = 32'h0000_0400;
    doOp(2, 0, '0, 0, "R7");
    check("R7 OR single", reduceData, redM);
    check("R7 OR single value", reduceData, pattern(10, 33));
    peEnable = 32'h8421_0000;
    doOp(2, 0, '0, 0, "R7");
    check("R7 OR partial", reduceData, redM);
    held = reduceData;
    peEnable = '1;
    doOp(1, 0, 32'h7777_7777, 0, "R7");
    check("R7 held across broadcast", reduceData, held);
    peEnable = '0;
    doOp(2, 0, '0, 0, "R7");
    check("R7 OR none", reduceData, 0);

    // R9 reserved opcode never raises busy
    @(negedge clk);
    start = 1'b1; opcode = 2'd3;
    @(negedge clk);
    start = 1'b0;
    check("R9 opcode 3 busy", WIDTH'(busy), 0);
    @(negedge clk);
    check("R9 opcode 3 done", WIDTH'(done), 0);
    checkAll("R9 opcode 3 no effect");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule